// File: doc/BRIEF.md
# Fetch Sequencer with One-Instruction Branch Delay

This block keeps the program counter for a 32-bit instruction stream whose addresses advance in steps of four bytes. It sends a fetch address to a synchronous instruction memory. The word read there comes back on the next clock edge. The block then presents that word, together with its address, as the issued instruction. A small decoder outside the block inspects the issued word and answers in the same cycle with a branch request. The request is either a relative branch, whose target is a signed word displacement from the branch's own address, or a vectored branch, whose target is a register value.

Every taken branch has exactly one delay slot. The instruction that follows a taken branch is always fetched and issued, and is flagged as a delay-slot instruction, before control moves to the target. A branch request made by a delay-slot instruction is ignored. For branches that link, the block raises a register-write request that carries the return address and the index of the register that receives it.

An unused delay slot is normally filled with the no-op word 0x08000240, which ORs register 0 with itself into register 0. The block does not decode instructions, so this word simply flows through like any other. A stall input freezes the sequence.

Top module: `fetch_dslot`

## Requirements
- R1: While reset is asserted, issue_valid is 0. The first instruction issued after reset is at address 0.
- R2: While stall is high, issue_valid is 0 and no branch request is accepted. The issued address and the delay-slot state hold through the stall, and the same word is issued again once stall falls.
- R3: Without a taken branch, the address issued next is the current issued address plus 4.
- R4: When a branch at address P is taken, the next instruction issued is at P+4, with issue_slot at 1. The instruction issued after that one is at the branch target.
- R5: For br_kind 0 and 1 (relative), the target is P plus the sign-extended br_disp shifted left by 2.
- R6: For br_kind 2 and 3 (vectored), the target is br_reg with its two low bits forced to 0.
- R7: A branch request made while issue_slot is 1 causes no redirect and no link write.
- R8: A taken branch of br_kind 0 writes register 2. A taken branch of br_kind 1 or 3 writes register 31. br_kind 2 makes no link write.
- R9: The link value is P+8, the address that follows the delay slot. link_we is raised in the same cycle the branch issues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Freezes issue and the program counter |
| imem_addr | output | 32 | Byte address for the synchronous memory read |
| imem_rdata | input | 32 | Word read on the previous edge |
| issue_valid | output | 1 | An instruction is issued this cycle |
| issue_pc | output | 32 | Address of the issued instruction |
| issue_instr | output | 32 | Issued instruction word |
| issue_slot | output | 1 | Issued instruction sits in a delay slot |
| br_valid | input | 1 | Decoder reports a branch in the issued word |
| br_kind | input | 2 | 0 relative link r2, 1 relative link r31, 2 vectored, 3 vectored link r31 |
| br_disp | input | DISP_W | Signed word displacement for relative branches |
| br_reg | input | 32 | Register value for vectored branches |
| link_we | output | 1 | Link register write request |
| link_idx | output | 5 | Link destination register |
| link_data | output | 32 | Return address |

## Verification
Two pairs of events can land in the same cycle, and both must be judged. The first pair is a branch that sits in a delay slot: the program places branch words directly after taken branches, and a reference model checks that there is no redirect and no link write. The second pair is a stall that arrives while a branch or its delay slot is waiting to issue. The stall is applied on a repeating pattern whose phase drifts against the program loop, so over time it hits both branches and delay slots. The model then checks that the redirect and the link are only deferred, never lost or doubled. Every clock, the model compares the issue, slot, address and link outputs.

// File: rtl/fetch_dslot.sv
module fetch_dslot #(
  parameter int          DISP_W   = 17,
  parameter logic [31:0] RESET_PC = 32'h0,
  parameter logic [4:0]  RP_REG   = 5'd2,
  parameter logic [4:0]  ALT_REG  = 5'd31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall,
  output logic [31:0]       imem_addr,
  input  logic [31:0]       imem_rdata,
  output logic              issue_valid,
  output logic [31:0]       issue_pc,
  output logic [31:0]       issue_instr,
  output logic              issue_slot,
  input  logic              br_valid,
  input  logic [1:0]        br_kind,
  input  logic [DISP_W-1:0] br_disp,
  input  logic [31:0]       br_reg,
  output logic              link_we,
  output logic [4:0]        link_idx,
  output logic [31:0]       link_data
);

  localparam int EXT_W = 32 - DISP_W - 2;

  logic        valid_q, slot_q;
  logic [31:0] pc_q, tgt_q, pc_next, target;
  logic        issue, take;

  assign issue = valid_q & ~stall;
  assign take  = issue & br_valid & ~slot_q;

  assign target = br_kind[1] ? {br_reg[31:2], 2'b00}
                             : pc_q + {{EXT_W{br_disp[DISP_W-1]}}, br_disp, 2'b00};

  always_comb begin
    if (!issue)      pc_next = pc_q;
    else if (slot_q) pc_next = tgt_q;
    else             pc_next = pc_q + 32'd4;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      slot_q  <= 1'b0;
      pc_q    <= RESET_PC;
      tgt_q   <= RESET_PC;
    end else begin
      valid_q <= 1'b1;
      pc_q    <= pc_next;
      if (take) begin
        slot_q <= 1'b1;
        tgt_q  <= target;
      end else if (issue) begin
        slot_q <= 1'b0;
      end
    end
  end

  assign imem_addr   = pc_next;
  assign issue_valid = issue;
  assign issue_pc    = pc_q;
  assign issue_instr = imem_rdata;
  assign issue_slot  = slot_q;
  assign link_we     = take & (br_kind != 2'd2);
  assign link_idx    = (br_kind == 2'd0) ? RP_REG : ALT_REG;
  assign link_data   = pc_q + 32'd8;

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && stall) |=> ($stable(pc_q) && $stable(slot_q)));
  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && !slot_q) |=> (pc_q == $past(pc_q) + 32'd4));
  a_r4_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && slot_q) |=> (pc_q == $past(tgt_q)));
  a_r4_slot_follows: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> slot_q);
  a_r6_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (take && br_kind[1]) |=> (tgt_q[1:0] == 2'b00));
  a_r7_no_link_in_slot: assert property (@(posedge clk) disable iff (!rst_n)
    slot_q |-> !link_we);

endmodule

// File: tb/fetch_dslot_test.sv
module fetch_dslot_test;
  localparam int DISP_W = 17;
  localparam logic [31:0] NOP = 32'h0800_0240;

  logic clk = 0, rst_n = 0, stall = 0;
  logic [31:0] imem_addr, imem_rdata, issue_pc, issue_instr, br_reg, link_data;
  logic issue_valid, issue_slot, br_valid, link_we;
  logic [1:0] br_kind;
  logic [DISP_W-1:0] br_disp;
  logic [4:0] link_idx;
  logic [31:0] rom [0:63];

  int errors = 0, checks = 0, cyc = 0;

  always #5 clk = ~clk;

  fetch_dslot #(.DISP_W(DISP_W)) uut (
    .clk(clk), .rst_n(rst_n), .stall(stall), .imem_addr(imem_addr),
    .imem_rdata(imem_rdata), .issue_valid(issue_valid), .issue_pc(issue_pc),
    .issue_instr(issue_instr), .issue_slot(issue_slot), .br_valid(br_valid),
    .br_kind(br_kind), .br_disp(br_disp), .br_reg(br_reg), .link_we(link_we),
    .link_idx(link_idx), .link_data(link_data));

  always @(posedge clk) imem_rdata <= rom[imem_addr[7:2]];

  assign br_valid = issue_instr[31];
  assign br_kind  = issue_instr[30:29];
  assign br_disp  = issue_instr[DISP_W-1:0];
  assign br_reg   = {16'h0, issue_instr[15:0]};

  function automatic logic [31:0] br(input logic [1:0] k, input int v);
    logic [31:0] w;
    w = {1'b1, k, 29'h0};
    w[DISP_W-1:0] = v[DISP_W-1:0];
    return w;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc=%0d actual=%h expected=%h", tag, cyc, act, exp);
    end
  endtask

  logic        m_valid = 0, m_slot = 0;
  logic [31:0] m_pc = 0, m_tgt = 0;
  string       m_why = "R1";

  always @(negedge clk) begin
    logic [31:0] w, t;
    logic m_issue, m_take;
    if (!rst_n) begin
      chk("R1 issue_valid in reset", {31'b0, issue_valid}, 0);
      m_valid = 0; m_slot = 0; m_pc = 0; m_tgt = 0; m_why = "R1";
    end else begin
      w = rom[m_pc[7:2]];
      m_issue = m_valid && !stall;
      m_take  = m_issue && w[31] && !m_slot;
      chk("R2 issue_valid", {31'b0, issue_valid}, {31'b0, m_issue});
      if (m_valid) begin
        chk({m_why, " issue_pc"}, issue_pc, m_pc);
        chk("R4 issue_slot", {31'b0, issue_slot}, {31'b0, m_slot});
        chk(m_slot && w[31] ? "R7 link_we" : "R8 link_we", {31'b0, link_we},
            {31'b0, m_take && w[30:29] != 2'd2});
        if (m_take) begin
          chk("R9 link_data", link_data, m_pc + 8);
          if (w[30:29] != 2'd2)
            chk("R8 link_idx", {27'b0, link_idx}, (w[30:29] == 2'd0) ? 32'd2 : 32'd31);
        end
      end
      if (!m_valid) begin
        m_valid = 1; m_pc = 0; m_why = "R1";
      end else if (!m_issue) begin
        m_why = "R2";
      end else if (m_slot) begin
        m_why = (m_tgt[31]) ? "R6" : "R5";
        m_pc = {1'b0, m_tgt[30:0]};
        m_slot = 0;
      end else begin
        if (m_take) begin
          if (w[30]) t = {1'b1, 15'h0, w[15:2], 2'b00};
          else t = {1'b0, m_pc[30:0] + 31'($signed(w[DISP_W-1:0]) * 4)};
          m_tgt = t; m_slot = 1; m_why = "R4";
        end else m_why = "R3";
        m_pc = m_pc + 4;
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) rom[i] = NOP;
    rom[2]  = br(2'd0, 6);
    rom[9]  = br(2'd2, 32'h53);
    rom[10] = br(2'd0, -10);
    rom[20] = br(2'd3, 32'h30);
    rom[12] = br(2'd1, -12);
    rom[13] = br(2'd1, 5);
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    for (int i = 0; i < 400; i++) begin
      @(posedge clk);
      #1;
      cyc = i;
      stall = (i >= 60 && i < 200) ? ((i % 5 == 2) || (i % 7 == 4)) : (i >= 260 && i % 3 == 0);
      if (i == 230) rst_n = 0;
      if (i == 234) rst_n = 1;
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #100000;
    errors++; checks++;
    $display("FAIL watchdog expired cyc=%0d actual=running expected=done", cyc);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule